// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block watches a received Ethernet frame one byte at a time and, when the last byte arrives, decides whether the frame is kept or thrown away and what length to report for it. The byte stream comes with first-byte and last-byte markers. A CRC engine elsewhere supplies a pass/fail flag for the frame check sequence with the last byte. A length guard elsewhere raises a too-long indication during reception. Three configuration inputs select the options: drop the four FCS bytes from the reported length, accept frames whose FCS failed, and discard frames that are shorter than their own length/type field.

The verdict, the reported length and a bad-FCS status bit come out together as a one-cycle result strobe, one clock after the last byte. A receive path uses the strobe to commit or roll back the frame it has already buffered. The block does not compute the CRC, filter addresses or handle buffers.

Top module: `rx_frame_checker`

## Requirements
- R1: The measured length is the number of bytes accepted from the first-byte marker through the last-byte marker inclusive, and a frame of a single byte carrying both markers measures 1. With stripping off, `res_len` equals the measured length.
- R2: With `cfg_len_chk` high, the byte at zero-based position 12 is the high-order byte of the length field and position 13 is the low-order byte. A frame whose measured length is smaller than that field is discarded (`res_keep` low).
- R3: The length comparison applies only when the measured length is from 64 to 1518 bytes inclusive. Outside that window the field never causes a discard.
- R4: A length field value above 1500 is a type code and is never compared.
- R5: With `cfg_strip_fcs` high, `res_len` is the measured length minus 4, with a floor of 0.
- R6: A frame with `fcs_ok` low on its last byte is discarded unless `cfg_keep_bad_fcs` is high.
- R7: `res_fcs_bad` equals the inverse of `fcs_ok` sampled on the last byte, whatever `cfg_keep_bad_fcs` is set to.
- R8: A frame during which `too_long` was high on any accepted byte, the first and last included, is discarded.
- R9: `res_valid` is high for exactly the one cycle after each cycle that accepts a last byte. In all other cycles `res_valid`, `res_keep`, `res_len` and `res_fcs_bad` are 0.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| fcs_ok | input | 1 | FCS check passed, sampled with the last byte |
| too_long | input | 1 | Frame exceeded the allowed size |
| cfg_strip_fcs | input | 1 | Report length without the FCS bytes |
| cfg_keep_bad_fcs | input | 1 | Keep frames whose FCS failed |
| cfg_len_chk | input | 1 | Enable the length-field discard |
| res_valid | output | 1 | Result strobe, one cycle |
| res_keep | output | 1 | Frame is good and kept |
| res_len | output | LEN_W (16) | Reported frame length |
| res_fcs_bad | output | 1 | FCS of this frame failed |

## Verification
Every bad internal state shows up at the ports on the next result strobe, one cycle after the last byte. A byte counter that skips or repeats a step appears as a wrong `res_len` on that strobe. A field byte latched from the wrong position shows as a discard decision that flips at the wrong field values around the 64-byte window edge. A too-long flag that is not cleared between frames would wrongly discard the following frame. The bench sweeps frame lengths, field values, FCS status and all eight option settings, so each of these faults is exposed within one frame.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
   localparam int FIELD_W = 16;

   typedef struct packed {
      logic keep;
      logic fcs_bad;
   } rxv_flags_t;

   function automatic rxv_flags_t rxv_judge(input logic fcs_ok, input logic keep_bad_fcs,
                                            input logic oversize, input logic len_err);
      rxv_flags_t f;
      f.fcs_bad = ~fcs_ok;
      f.keep    = ~oversize & ~len_err & (fcs_ok | keep_bad_fcs);
      return f;
   endfunction
endpackage

// File: rtl/rxv_byte_tracker.sv
module rxv_byte_tracker
   import rxv_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int FIELD_POS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_first,
   input  logic               too_long,
   output logic [LEN_W-1:0]   count_nx,
   output logic [FIELD_W-1:0] field_nx,
   output logic               oversize_nx
);
   localparam logic [LEN_W-1:0] CNT_MAX = '1;
   localparam logic [LEN_W-1:0] POS_HI  = LEN_W'(FIELD_POS);
   localparam logic [LEN_W-1:0] POS_LO  = LEN_W'(FIELD_POS + 1);

   logic [LEN_W-1:0]   count_q;
   logic [FIELD_W-1:0] field_q;
   logic               oversize_q;
   logic [LEN_W-1:0]   pos;
   logic [FIELD_W-1:0] field_base;

   assign pos        = in_first ? '0 : count_q;
   assign field_base = (in_valid && in_first) ? '0 : field_q;

   always_comb begin
      count_nx = count_q;
      if (in_valid) begin
         if (in_first)               count_nx = LEN_W'(1);
         else if (count_q != CNT_MAX) count_nx = count_q + LEN_W'(1);
      end
   end

   always_comb begin
      field_nx = field_base;
      if (in_valid && pos == POS_HI) field_nx[15:8] = in_data;
      if (in_valid && pos == POS_LO) field_nx[7:0]  = in_data;
   end

   assign oversize_nx = ((in_valid && in_first) ? 1'b0 : oversize_q) | (in_valid & too_long);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q    <= '0;
         field_q    <= '0;
         oversize_q <= 1'b0;
      end else begin
         count_q    <= count_nx;
         field_q    <= field_nx;
         oversize_q <= oversize_nx;
      end
   end

   // R1: each continuing byte advances the count by one until saturation
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_first && count_q != CNT_MAX |=> count_q == $past(count_q) + LEN_W'(1));
   // R1: a first byte restarts the count at one
   a_r1_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_first |=> count_q == LEN_W'(1));
endmodule

// File: rtl/rxv_len_rule.sv
module rxv_len_rule
   import rxv_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int WIN_MIN  = 64,
   parameter int WIN_MAX  = 1518,
   parameter int TYPE_MIN = 1501
) (
   input  logic               enable,
   input  logic [LEN_W-1:0]   measured,
   input  logic [FIELD_W-1:0] field,
   output logic               len_err
);
   localparam int CW = (LEN_W > FIELD_W) ? LEN_W : FIELD_W;

   logic [CW-1:0] m_w, f_w;
   logic          in_win, is_len;

   assign m_w    = CW'(measured);
   assign f_w    = CW'(field);
   assign in_win = (m_w >= CW'(WIN_MIN)) && (m_w <= CW'(WIN_MAX));
   assign is_len = f_w < CW'(TYPE_MIN);
   assign len_err = enable && in_win && is_len && (m_w < f_w);
endmodule

// File: rtl/rxv_len_report.sv
module rxv_len_report #(
   parameter int LEN_W     = 16,
   parameter int FCS_BYTES = 4
) (
   input  logic             strip,
   input  logic [LEN_W-1:0] measured,
   output logic [LEN_W-1:0] reported
);
   generate
      if (FCS_BYTES == 0) begin : g_no_fcs
         logic unused_strip;
         assign unused_strip = strip;
         assign reported     = measured;
      end else begin : g_strip
         localparam logic [LEN_W-1:0] FCS_L = LEN_W'(FCS_BYTES);
         always_comb begin
            if (!strip)                reported = measured;
            else if (measured < FCS_L) reported = '0;
            else                       reported = measured - FCS_L;
         end
      end
   endgenerate
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
   import rxv_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int FIELD_POS = 12,
   parameter int WIN_MIN   = 64,
   parameter int WIN_MAX   = 1518,
   parameter int TYPE_MIN  = 1501,
   parameter int FCS_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_first,
   input  logic             in_last,
   input  logic             fcs_ok,
   input  logic             too_long,
   input  logic             cfg_strip_fcs,
   input  logic             cfg_keep_bad_fcs,
   input  logic             cfg_len_chk,
   output logic             res_valid,
   output logic             res_keep,
   output logic [LEN_W-1:0] res_len,
   output logic             res_fcs_bad
);
   generate
      if (LEN_W < 11 || LEN_W > 32) begin : g_bad_len_w
         $error("LEN_W must lie in 11..32");
      end
      if (WIN_MIN > WIN_MAX || WIN_MAX >= (1 << LEN_W)) begin : g_bad_window
         $error("length window is empty or wider than the counter");
      end
      if (FIELD_POS < 0 || FIELD_POS + 2 > WIN_MIN) begin : g_bad_pos
         $error("length field must sit inside the smallest checked frame");
      end
      if (FCS_BYTES < 0 || FCS_BYTES > 8) begin : g_bad_fcs
         $error("FCS_BYTES must lie in 0..8");
      end
   endgenerate

   logic [LEN_W-1:0]   count_nx, rep_len;
   logic [FIELD_W-1:0] field_nx;
   logic               oversize_nx, len_err, take_last;
   rxv_flags_t         flags;

   assign take_last = in_valid & in_last;

   rxv_byte_tracker #(.LEN_W(LEN_W), .FIELD_POS(FIELD_POS)) u_track (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_first(in_first), .too_long(too_long),
      .count_nx(count_nx), .field_nx(field_nx), .oversize_nx(oversize_nx)
   );

   rxv_len_rule #(.LEN_W(LEN_W), .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX), .TYPE_MIN(TYPE_MIN)) u_rule (
      .enable(cfg_len_chk), .measured(count_nx), .field(field_nx), .len_err(len_err)
   );

   rxv_len_report #(.LEN_W(LEN_W), .FCS_BYTES(FCS_BYTES)) u_rep (
      .strip(cfg_strip_fcs), .measured(count_nx), .reported(rep_len)
   );

   assign flags = rxv_judge(fcs_ok, cfg_keep_bad_fcs, oversize_nx, len_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_keep    <= 1'b0;
         res_len     <= '0;
         res_fcs_bad <= 1'b0;
      end else if (take_last) begin
         res_valid   <= 1'b1;
         res_keep    <= flags.keep;
         res_len     <= rep_len;
         res_fcs_bad <= flags.fcs_bad;
      end else begin
         res_valid   <= 1'b0;
         res_keep    <= 1'b0;
         res_len     <= '0;
         res_fcs_bad <= 1'b0;
      end
   end

   // R9: strobe follows each accepted last byte and nothing else
   a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_last |=> res_valid);
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_last) |=> !res_valid && !res_keep && !res_fcs_bad && res_len == '0);
   // R8: oversize on the final byte always discards
   a_r8_oversize: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_last && too_long |=> !res_keep);
   // R6: bad FCS without the keep option discards
   a_r6_fcs_drop: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_last && !fcs_ok && !cfg_keep_bad_fcs |=> !res_keep);
   // R7: bad FCS is always flagged
   a_r7_fcs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_last |=> res_fcs_bad == !$past(fcs_ok));
endmodule

// File: tb/sim_rx_frame_checker.sv
module sim_rx_frame_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        fcs_ok = 1'b1, too_long = 1'b0;
   logic        cfg_strip_fcs = 1'b0, cfg_keep_bad_fcs = 1'b0, cfg_len_chk = 1'b0;
   logic        res_valid, res_keep, res_fcs_bad;
   logic [15:0] res_len;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rx_frame_checker u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_first(in_first), .in_last(in_last), .fcs_ok(fcs_ok), .too_long(too_long),
      .cfg_strip_fcs(cfg_strip_fcs), .cfg_keep_bad_fcs(cfg_keep_bad_fcs),
      .cfg_len_chk(cfg_len_chk), .res_valid(res_valid), .res_keep(res_keep),
      .res_len(res_len), .res_fcs_bad(res_fcs_bad)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // sends a frame; tl_at < 0 means too_long never raised
   task automatic send(input int len, input int field, input bit fok, input int tl_at,
                       input bit strip, input bit keepbad, input bit chk);
      int exp_len;
      bit len_err, exp_keep;
      cfg_strip_fcs = strip; cfg_keep_bad_fcs = keepbad; cfg_len_chk = chk;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_first = (i == 0);
         in_last  = (i == len - 1);
         in_data  = (i == 12) ? field[15:8] : (i == 13) ? field[7:0] : 8'(i * 7 + 3);
         too_long = (i == tl_at);
         fcs_ok   = (i == len - 1) ? fok : ~fok;
      end
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; too_long = 1'b0; fcs_ok = 1'b1;
      // R2 R3 R4: discard rule, computed from the requirements
      len_err  = chk && len >= 64 && len <= 1518 && field <= 1500 && len < field;
      exp_keep = (tl_at < 0) && !len_err && (fok || keepbad);
      exp_len  = strip ? ((len >= 4) ? len - 4 : 0) : len;
      check("R9 strobe", int'(res_valid), 1);
      check("R2/R3/R4/R6/R8 keep", int'(res_keep), int'(exp_keep));
      check(strip ? "R5 stripped length" : "R1 length", int'(res_len), exp_len);
      check("R7 fcs flag", int'(res_fcs_bad), int'(!fok));
      @(negedge clk);
      check("R9 one cycle", int'(res_valid), 0);
      check("R9 idle zero", int'(res_keep) + int'(res_len) + int'(res_fcs_bad), 0);
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      int lens[12]   = '{1, 3, 4, 5, 13, 14, 15, 63, 64, 65, 100, 200};
      int fields[8]  = '{0, 50, 64, 65, 100, 1500, 1501, 16'h0800};
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset valid", int'(res_valid), 0);
      check("R10 reset outputs", int'(res_keep) + int'(res_len) + int'(res_fcs_bad), 0);
      rst_n = 1'b1;
      @(negedge clk);
      foreach (lens[li])
         foreach (fields[fi])
            for (int c = 0; c < 8; c++)
               for (int f = 0; f < 2; f++)
                  send(lens[li], fields[fi], f[0], -1, c[0], c[1], c[2]);
      // R3: upper window edge
      send(1518, 1500, 1'b1, -1, 1'b0, 1'b0, 1'b1);
      send(1519, 1500, 1'b1, -1, 1'b1, 1'b0, 1'b1);
      // R8: too_long on first, middle, last byte, then a clean frame after it
      send(80, 40, 1'b1, 0, 1'b0, 1'b1, 1'b0);
      send(80, 40, 1'b1, 37, 1'b1, 1'b1, 1'b1);
      send(80, 40, 1'b1, 79, 1'b0, 1'b0, 1'b0);
      send(80, 40, 1'b1, -1, 1'b0, 1'b0, 1'b0);
      send(1, 0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
      summary();
   end
endmodule